// File: doc/BRIEF.md
# Flash Status and Write-Protection Controller

This block owns the status byte of a serial flash device and decides whether each program or erase request may start. A command decoder upstream hands it one-cycle strobes for write-enable, write-disable, status-write enable and status write, along with program and erase requests that carry an operation kind and a target byte address. It also watches the active-low write-protect pin.

A request is granted only when three things hold. The write-enable latch must be set, no earlier operation may still be busy, and the target must lie outside the region named by the two block-protection bits. A granted request raises busy until the execution engine reports completion. A rejected request pulses a reject flag and changes nothing.

Status writes are a two-step sequence: an enable-status-write strobe followed directly by the write. They are refused while the lock bit is set and the protect pin is low. The execution engine and the serial shifter sit outside this block.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset, status_o reads 8'h8C. The status byte layout is bit 7 lock, bit 6 auto-increment mode, bits 5:4 zero, bit 3 BP1, bit 2 BP0, bit 1 write-enable latch, bit 0 busy.
- R2: When not busy, a write-enable strobe sets the latch. A write-disable strobe clears both the latch and the auto-increment flag.
- R3: One cycle after op_req_i, exactly one of op_grant_o and op_reject_o pulses. A grant requires the latch set, busy clear, a valid kind (0 byte program, 1 auto-increment program, 2 sector erase, 3 block erase, 4 chip erase) and an unprotected target.
- R4: With ADDR_W address bits, BP=00 protects nothing, BP=01 protects addresses at or above 3/4 of the array, BP=10 protects addresses at or above 1/2, and BP=11 protects all addresses.
- R5: A chip erase is rejected whenever BP is not 00.
- R6: A status write changes status only if the most recent preceding strobe or request was the enable-status-write strobe.
- R7: While lock=1 and wp_ni=0, a status write changes nothing.
- R8: A grant sets busy in the same cycle that op_grant_o rises. While busy, write-enable, write-disable and status strobes are ignored, and requests are rejected.
- R9: op_done_i while busy clears busy. It also clears the latch, unless the granted kind was auto-increment program, which sets the auto-increment flag and keeps the latch.
- R10: A status write loads only lock, BP1 and BP0. The other status bits are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wp_ni | input | 1 | Write-protect pin, active low |
| wren_i | input | 1 | Write-enable strobe |
| wrdi_i | input | 1 | Write-disable strobe |
| ewsr_i | input | 1 | Enable-status-write strobe |
| wrsr_i | input | 1 | Status-write strobe |
| wrsr_bp_i | input | 2 | BP1:BP0 value for a status write |
| wrsr_lock_i | input | 1 | Lock value for a status write |
| op_req_i | input | 1 | Program/erase request strobe |
| op_kind_i | input | 3 | Operation kind, encoded as in R3 |
| op_addr_i | input | ADDR_W | Target byte address |
| op_done_i | input | 1 | Completion pulse from the execution engine |
| op_grant_o | output | 1 | Request accepted, one-cycle pulse |
| op_reject_o | output | 1 | Request refused, one-cycle pulse |
| status_o | output | 8 | Status byte, layout as in R1 |

## Verification
The bench sweeps every BP setting against every operation kind and every address quarter, probing the address just below and just at each protection boundary. A decoder that is off by one at a boundary would grant a write into protected space or refuse a legal one. It checks that the enable strobe only arms the very next command: a design that kept the arm flag across an intervening write-enable would accept an unarmed status write. It also drives the lock bit together with a low protect pin, and sends strobes while busy, where a design that leaked them would change BP or drop the latch in the middle of an operation. After each completion the bench checks whether the latch survives, which catches an auto-increment program that loses its latch or a byte program that keeps it.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  typedef enum logic [2:0] {
    OP_BYTE = 3'd0,
    OP_AAI  = 3'd1,
    OP_SECT = 3'd2,
    OP_BLK  = 3'd3,
    OP_CHIP = 3'd4
  } op_kind_e;

  localparam int unsigned ST_BUSY = 0;
  localparam int unsigned ST_WEL  = 1;
  localparam int unsigned ST_BP0  = 2;
  localparam int unsigned ST_BP1  = 3;
  localparam int unsigned ST_AAI  = 6;
  localparam int unsigned ST_LOCK = 7;
endpackage

// File: rtl/fwp_region_dec.sv
module fwp_region_dec
  import flash_wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic [1:0]        bp_i,
  input  logic [2:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);
  localparam logic [ADDR_W-1:0] BASE_QTR = ADDR_W'(3) << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] BASE_HALF = ADDR_W'(1) << (ADDR_W - 1);

  logic addr_prot;

  always_comb begin
    unique case (bp_i)
      2'b00:   addr_prot = 1'b0;
      2'b01:   addr_prot = (addr_i >= BASE_QTR);
      2'b10:   addr_prot = (addr_i >= BASE_HALF);
      default: addr_prot = 1'b1;
    endcase
  end

  // chip erase needs a fully open array; unknown kinds are refused
  assign prot_o = addr_prot
                | ((kind_i == OP_CHIP) && (bp_i != 2'b00))
                | (kind_i > OP_CHIP);
endmodule

// File: rtl/fwp_status_reg.sv
module fwp_status_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wp_ni,
  input  logic       wren_i,
  input  logic       wrdi_i,
  input  logic       ewsr_i,
  input  logic       wrsr_i,
  input  logic [1:0] wrsr_bp_i,
  input  logic       wrsr_lock_i,
  input  logic       req_i,
  input  logic       grant_i,
  input  logic       grant_aai_i,
  input  logic       done_i,
  output logic       busy_o,
  output logic       wel_o,
  output logic       aai_o,
  output logic [1:0] bp_o,
  output logic       lock_o
);
  logic       busy_q, wel_q, aai_q, lock_q, armed_q;
  logic [1:0] bp_q;
  logic       any_cmd, locked;

  assign any_cmd = wren_i | wrdi_i | ewsr_i | wrsr_i | req_i;
  assign locked  = lock_q & ~wp_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      wel_q   <= 1'b0;
      aai_q   <= 1'b0;
      bp_q    <= 2'b11;
      lock_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (busy_q) begin
      if (done_i) begin
        busy_q <= 1'b0;
        if (!aai_q) wel_q <= 1'b0;
      end
    end else begin
      if (any_cmd) armed_q <= ewsr_i;
      if (grant_i) begin
        busy_q <= 1'b1;
        aai_q  <= grant_aai_i;
      end
      if (wren_i) wel_q <= 1'b1;
      if (wrdi_i) begin
        wel_q <= 1'b0;
        aai_q <= 1'b0;
      end
      if (wrsr_i && armed_q && !locked) begin
        bp_q   <= wrsr_bp_i;
        lock_q <= wrsr_lock_i;
      end
    end
  end

  assign busy_o = busy_q;
  assign wel_o  = wel_q;
  assign aai_o  = aai_q;
  assign bp_o   = bp_q;
  assign lock_o = lock_q;

  AST_LOCK_FREEZES_BP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !wp_ni) |=> ($stable(bp_q) && $stable(lock_q))); // R7
  AST_UNARMED_WRSR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrsr_i && !armed_q) |=> ($stable(bp_q) && $stable(lock_q))); // R6
  AST_BUSY_FREEZES_BP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_i) |=> ($stable(bp_q) && busy_q && $stable(wel_q))); // R8
  AST_DONE_DROPS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && done_i && !aai_q) |=> (!busy_q && !wel_q)); // R9
  AST_WREN_SETS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && wren_i) |=> wel_q); // R2
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import flash_wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_ni,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              ewsr_i,
  input  logic              wrsr_i,
  input  logic [1:0]        wrsr_bp_i,
  input  logic              wrsr_lock_i,
  input  logic              op_req_i,
  input  logic [2:0]        op_kind_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic              op_done_i,
  output logic              op_grant_o,
  output logic              op_reject_o,
  output logic [7:0]        status_o
);
  logic       busy, wel, aai, lock, prot, req_ok;
  logic [1:0] bp;
  logic       grant_q, reject_q;

  fwp_region_dec #(.ADDR_W(ADDR_W)) u_dec (
    .bp_i   (bp),
    .kind_i (op_kind_i),
    .addr_i (op_addr_i),
    .prot_o (prot)
  );

  assign req_ok = op_req_i & ~busy & wel & ~prot;

  fwp_status_reg u_st (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wp_ni       (wp_ni),
    .wren_i      (wren_i),
    .wrdi_i      (wrdi_i),
    .ewsr_i      (ewsr_i),
    .wrsr_i      (wrsr_i),
    .wrsr_bp_i   (wrsr_bp_i),
    .wrsr_lock_i (wrsr_lock_i),
    .req_i       (op_req_i),
    .grant_i     (req_ok),
    .grant_aai_i (op_kind_i == OP_AAI),
    .done_i      (op_done_i),
    .busy_o      (busy),
    .wel_o       (wel),
    .aai_o       (aai),
    .bp_o        (bp),
    .lock_o      (lock)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q  <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      grant_q  <= req_ok;
      reject_q <= op_req_i & ~req_ok;
    end
  end

  assign op_grant_o  = grant_q;
  assign op_reject_o = reject_q;

  always_comb begin
    status_o          = '0;
    status_o[ST_BUSY] = busy;
    status_o[ST_WEL]  = wel;
    status_o[ST_BP0]  = bp[0];
    status_o[ST_BP1]  = bp[1];
    status_o[ST_AAI]  = aai;
    status_o[ST_LOCK] = lock;
  end

  AST_GRANT_XOR_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(op_grant_o && op_reject_o)); // R3
  AST_GRANT_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_req_i |=> (op_grant_o == $past(wel && !busy && !prot))); // R3
  AST_GRANT_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_grant_o |-> busy); // R8
  AST_CHIP_NEEDS_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_req_i && op_kind_i == OP_CHIP && bp != 2'b00) |=> op_reject_o); // R5
endmodule

// File: tb/flash_wp_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_wp_ctrl_tb_top;
  localparam int unsigned AW = 20;
  localparam int unsigned SZ = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, wp_n = 1'b1;
  logic wren = 0, wrdi = 0, ewsr = 0, wrsr = 0, wlock = 0, req = 0, done = 0;
  logic [1:0] wbp = 0;
  logic [2:0] kind = 0;
  logic [AW-1:0] addr = 0;
  logic grant, reject;
  logic [7:0] status;
  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flash_wp_ctrl #(.ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wp_ni(wp_n), .wren_i(wren), .wrdi_i(wrdi),
    .ewsr_i(ewsr), .wrsr_i(wrsr), .wrsr_bp_i(wbp), .wrsr_lock_i(wlock),
    .op_req_i(req), .op_kind_i(kind), .op_addr_i(addr), .op_done_i(done),
    .op_grant_o(grant), .op_reject_o(reject), .status_o(status)
  );

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] st(input bit lk, input bit ai, input int bp,
                                    input bit we, input bit by);
    return {lk, ai, 2'b00, 2'(bp), we, by};
  endfunction

  task automatic tick(); @(negedge clk); endtask
  task automatic p_wren(); wren = 1; tick(); wren = 0; endtask
  task automatic p_wrdi(); wrdi = 1; tick(); wrdi = 0; endtask
  task automatic p_ewsr(); ewsr = 1; tick(); ewsr = 0; endtask
  task automatic p_done(); done = 1; tick(); done = 0; endtask
  task automatic p_wrsr(input int bp, input bit lk);
    wbp = 2'(bp); wlock = lk; wrsr = 1; tick(); wrsr = 0;
  endtask
  task automatic p_req(input int k, input int a);
    kind = 3'(k); addr = AW'(a); req = 1; tick(); req = 0;
  endtask
  task automatic set_bp(input int bp, input bit lk);
    wp_n = 1; p_ewsr(); p_wrsr(bp, lk);
  endtask

  function automatic bit prot_of(input int bp, input int k, input int a);
    if (k == 4 && bp != 0) return 1;
    case (bp)
      0: return 0;
      1: return a >= (SZ / 4) * 3;
      2: return a >= SZ / 2;
      default: return 1;
    endcase
  endfunction

  initial begin
    int addrs[8];
    addrs = '{0, SZ/2 - 1, SZ/2, (SZ/4)*3 - 1, (SZ/4)*3, SZ - 1, SZ/4, 4096};
    repeat (3) tick();
    chk("R1 reset status", status, 8'h8C);
    rst_n = 1; tick();
    chk("R1 after release", status, 8'h8C);
    chk("R1 grant idle", {6'b0, grant, reject}, 8'h00);

    // R6: unarmed write and write after an intervening strobe
    p_wrsr(0, 0);
    chk("R6 unarmed wrsr", status, 8'h8C);
    p_ewsr(); p_wren(); p_wrsr(0, 0);
    chk("R6 arm lost after wren", status, 8'h8E);
    p_wrdi();
    chk("R2 wrdi clears wel", status, 8'h8C);
    p_ewsr(); tick(); tick(); p_wrsr(0, 0);
    chk("R6 armed wrsr with idle gap", status, 8'h00);
    p_ewsr(); p_wrsr(3, 1);
    chk("R10 only lock and bp loaded", status, 8'h8C);

    // R3: request without the latch
    set_bp(0, 0);
    p_req(0, 0);
    chk("R3 no wel reject", {6'b0, grant, reject}, 8'h01);
    chk("R3 no wel status", status, 8'h00);

    // R4 R5 R9 sweep
    for (int bp = 0; bp < 4; bp++)
      for (int k = 0; k < 5; k++)
        for (int ai = 0; ai < 8; ai++) begin
          bit pr;
          pr = prot_of(bp, k, addrs[ai]);
          set_bp(bp, 0);
          p_wren();
          chk("R2 wren sets wel", status, st(0, 0, bp, 1, 0));
          p_req(k, addrs[ai]);
          chk(k == 4 ? "R5 chip erase decision" : "R4 region decision",
              {6'b0, grant, reject}, {6'b0, !pr, pr});
          if (!pr) begin
            chk("R8 busy on grant", status, st(0, k == 1, bp, 1, 1));
            p_done();
            chk("R9 done", status, st(0, k == 1, bp, k == 1, 0));
            if (k == 1) begin
              p_wrdi();
              chk("R2 wrdi ends auto mode", status, st(0, 0, bp, 0, 0));
            end
          end else begin
            chk("R3 reject keeps state", status, st(0, 0, bp, 1, 0));
            p_wrdi();
          end
        end

    // R8: strobes while busy
    set_bp(0, 0); p_wren(); p_req(2, 0);
    chk("R8 grant", {6'b0, grant, reject}, 8'h02);
    p_wrdi();
    chk("R8 wrdi ignored busy", status, 8'h03);
    p_ewsr(); p_wrsr(3, 1);
    chk("R8 wrsr ignored busy", status, 8'h03);
    p_req(0, 0);
    chk("R8 req rejected busy", {6'b0, grant, reject}, 8'h01);
    p_done();
    chk("R9 done clears wel", status, 8'h00);
    p_wren(); p_req(1, 0); p_done(); p_req(1, 4);
    chk("R9 auto mode regrant", {6'b0, grant, reject}, 8'h02);
    p_done(); p_wrdi();
    chk("R2 wrdi after auto", status, 8'h00);

    // R7: lock with the protect pin
    set_bp(0, 1);
    chk("R7 set lock", status, 8'h80);
    wp_n = 0; p_ewsr(); p_wrsr(3, 0);
    chk("R7 locked wrsr", status, 8'h80);
    wp_n = 1; p_ewsr(); p_wrsr(2, 0);
    chk("R7 pin high allows", status, 8'h08);
    wp_n = 0; p_ewsr(); p_wrsr(1, 0);
    chk("R7 lock clear allows", status, 8'h04);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule